// File: doc/BRIEF.md
# Parallel FPGA Configuration Loader

This block takes a raw configuration bitstream as a byte stream and writes it into a target FPGA through an 8-bit slave parallel configuration port. The loader generates the configuration clock itself. It pulses that clock only after a new byte has been stable on the data bus for a set time. Because nothing free-runs, the clock and chip select can never skew against each other or glitch.

A load begins with a `start` pulse. In the normal mode the loader first clears the target by holding the program pin low. It then waits for the target's init line to go high. After that it asserts chip select and the write direction and moves bytes across one at a time. After the last byte it keeps pulsing the clock so that the target can run its startup sequence, and it reports success once done is seen. In scrub mode the program pulse is skipped, so the running configuration is overwritten in place. The block reports an error in three cases: init drops during loading, init never rises, or done never arrives.

Top module: `cfg_loader`

## Requirements
- R1: After reset the program pin, chip select and read/write select are all high (inactive), the configuration clock is low, `s_ready` is low, and both `cfg_ok` and `cfg_err` are low.
- R2: A `start` with `scrub` low drives `tgt_prog_n` low for exactly PROG_CYC system clock cycles (64 cycles = 320 ns at 200 MHz by default). Chip select is never low while the program pin is low.
- R3: A `start` with `scrub` high never drives `tgt_prog_n` low.
- R4: `tgt_cs_n` and `tgt_rdwr_n` stay high until `tgt_init` has been seen high. They then go low together and stay low until the load ends.
- R5: Each byte accepted on the upstream side is captured by the target on exactly one rising edge of `tgt_cclk`, in acceptance order. The clock never pulses while chip select is high.
- R6: Every high phase of `tgt_cclk` lasts at least CLK_HI system cycles and every low phase at least CLK_LO cycles (each at least 2), which keeps the rate at or below 50 MHz. `tgt_data` does not change on a rising edge of `tgt_cclk`.
- R7: `s_ready` is low from the cycle after a byte is accepted until that byte's clock pulse has completed.
- R8: After the byte marked `s_last`, at least STARTUP_CLKS (8) further clock pulses are issued. `cfg_ok` rises when done has been seen and those pulses are complete. `cfg_ok` and `cfg_err` are never high together.
- R9: If `tgt_init` goes low while chip select is asserted, `cfg_err` rises and chip select returns high.
- R10: If done is not seen within DONE_TO startup pulses, `cfg_err` rises.
- R11: If `tgt_init` does not go high within INIT_TO cycles of the wait starting, `cfg_err` rises and chip select is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a load; ignored while busy |
| scrub | input | 1 | Sampled with start; high skips the program pulse |
| s_data | input | 8 | Upstream bitstream byte |
| s_valid | input | 1 | Upstream byte valid |
| s_last | input | 1 | Marks the final byte of the stream |
| s_ready | output | 1 | Loader can accept a byte |
| tgt_cclk | output | 1 | Configuration clock to target |
| tgt_cs_n | output | 1 | Active-low chip select |
| tgt_rdwr_n | output | 1 | Active-low write select (low = write) |
| tgt_prog_n | output | 1 | Active-low program (clear) pin |
| tgt_data | output | 8 | Configuration data bus |
| tgt_init | input | 1 | Target init status (high = ready) |
| tgt_done | input | 1 | Target done status |
| cfg_busy | output | 1 | Load in progress |
| cfg_ok | output | 1 | Load completed with done seen |
| cfg_err | output | 1 | Load failed |

## Verification
The assertions assume that `start` is only pulsed while the loader is idle or finished. They also assume that the target keeps init high for as long as it is healthy, and that done rises only after data has been clocked in. The bench models a target with these properties. Its init line rises a fixed delay after the program pin is released and stays high unless a scenario pulls it down on purpose. Its done line rises after a chosen number of captured clock edges. The upstream feeder raises valid only at falling edges and drops it after each accepted handshake.

// File: rtl/cfg_loader.sv
module cfg_loader #(
  parameter int CLK_HI      = 2,
  parameter int CLK_LO      = 2,
  parameter int PROG_CYC    = 64,
  parameter int INIT_TO     = 200,
  parameter int STARTUP_CLKS = 8,
  parameter int DONE_TO     = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       scrub,
  input  logic [7:0] s_data,
  input  logic       s_valid,
  input  logic       s_last,
  output logic       s_ready,
  output logic       tgt_cclk,
  output logic       tgt_cs_n,
  output logic       tgt_rdwr_n,
  output logic       tgt_prog_n,
  output logic [7:0] tgt_data,
  input  logic       tgt_init,
  input  logic       tgt_done,
  output logic       cfg_busy,
  output logic       cfg_ok,
  output logic       cfg_err
);
  localparam int HI  = (CLK_HI < 2) ? 2 : CLK_HI;
  localparam int LO  = (CLK_LO < 2) ? 2 : CLK_LO;
  localparam int CW  = 16;
  localparam int PW  = $clog2(DONE_TO + STARTUP_CLKS + 1) + 1;

  typedef enum logic [3:0] {IDLE, PROG, WINIT, LOAD, DLO, DHI, SLO, SHI, OKAY, FAIL} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pcnt;
  logic [7:0]    dat;
  logic          last_q, seen;

  wire selected = (st == LOAD) || (st == DLO) || (st == DHI) || (st == SLO) || (st == SHI);
  wire accept   = s_valid && s_ready;
  wire idle     = (st == IDLE) || (st == OKAY) || (st == FAIL);

  assign s_ready    = (st == LOAD);
  assign tgt_cclk   = (st == DHI) || (st == SHI);
  assign tgt_cs_n   = !selected;
  assign tgt_rdwr_n = !selected;
  assign tgt_prog_n = (st != PROG);
  assign tgt_data   = dat;
  assign cfg_busy   = !idle;
  assign cfg_ok     = (st == OKAY);
  assign cfg_err    = (st == FAIL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; pcnt <= '0; dat <= '0; last_q <= 1'b0; seen <= 1'b0;
    end else if (selected && !tgt_init) begin
      st <= FAIL;
    end else begin
      if ((st == SLO || st == SHI) && tgt_done) seen <= 1'b1;
      case (st)
        IDLE, OKAY, FAIL: if (start) begin
          seen <= 1'b0;
          if (scrub) begin st <= WINIT; cnt <= CW'(INIT_TO - 1); end
          else       begin st <= PROG;  cnt <= CW'(PROG_CYC - 1); end
        end
        PROG: if (cnt == 0) begin st <= WINIT; cnt <= CW'(INIT_TO - 1); end
              else cnt <= cnt - 1'b1;
        WINIT: if (tgt_init) st <= LOAD;
               else if (cnt == 0) st <= FAIL;
               else cnt <= cnt - 1'b1;
        LOAD: if (accept) begin
          dat <= s_data; last_q <= s_last; st <= DLO; cnt <= CW'(LO - 1);
        end
        DLO: if (cnt == 0) begin st <= DHI; cnt <= CW'(HI - 1); end
             else cnt <= cnt - 1'b1;
        DHI: if (cnt == 0) begin
          cnt <= CW'(LO - 1);
          if (last_q) begin st <= SLO; pcnt <= '0; end
          else st <= LOAD;
        end else cnt <= cnt - 1'b1;
        SLO: if (cnt == 0) begin st <= SHI; cnt <= CW'(HI - 1); pcnt <= pcnt + 1'b1; end
             else cnt <= cnt - 1'b1;
        SHI: if (cnt == 0) begin
          cnt <= CW'(LO - 1);
          if ((seen || tgt_done) && pcnt >= PW'(STARTUP_CLKS)) st <= OKAY;
          else if (pcnt >= PW'(DONE_TO)) st <= FAIL;
          else st <= SLO;
        end else cnt <= cnt - 1'b1;
        default: st <= IDLE;
      endcase
    end
  end

  assert_prog_cs_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!tgt_prog_n && !tgt_cs_n));
  assert_cs_after_init_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tgt_cs_n) |-> $past(tgt_init));
  assert_no_clk_unselected_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_cs_n |-> !tgt_cclk);
  assert_data_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tgt_cclk) |-> $stable(tgt_data));
  assert_ready_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !s_ready);
  assert_ok_err_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_ok && cfg_err));
  assert_init_loss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_cs_n && !tgt_init) |=> cfg_err);
endmodule

// File: tb/cfg_loader_tb.sv
module cfg_loader_tb;
  logic clk = 0, rst_n = 0;
  logic start = 0, scrub = 0, s_valid = 0, s_last = 0;
  logic [7:0] s_data = 0;
  logic s_ready, tgt_cclk, tgt_cs_n, tgt_rdwr_n, tgt_prog_n, cfg_busy, cfg_ok, cfg_err;
  logic [7:0] tgt_data;
  logic tgt_init, tgt_done;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  cfg_loader u_dut (.clk, .rst_n, .start, .scrub, .s_data, .s_valid, .s_last, .s_ready,
    .tgt_cclk, .tgt_cs_n, .tgt_rdwr_n, .tgt_prog_n, .tgt_data, .tgt_init, .tgt_done,
    .cfg_busy, .cfg_ok, .cfg_err);

  // target model
  logic [7:0] cap [0:255];
  int ncap = 0, done_at = 1000, init_dly = 10, init_cnt = 0;
  logic init_r = 0, hang_init = 0, kill_init = 0;
  assign tgt_init = init_r && !kill_init;
  assign tgt_done = (ncap >= done_at);
  always @(posedge tgt_cclk) if (!tgt_cs_n) begin
    if (ncap < 256) cap[ncap] <= tgt_data;
    ncap <= ncap + 1;
  end
  always @(posedge clk) begin
    if (!tgt_prog_n) begin init_r <= 0; init_cnt <= 0; end
    else if (!init_r && !hang_init) begin
      if (init_cnt >= init_dly) init_r <= 1; else init_cnt <= init_cnt + 1;
    end
  end

  // monitors
  int prog_low = 0, cs_early = 0, min_hi = 99, min_lo = 99, run = 0, pend = 0, ovl = 0;
  logic prev_clk = 0;
  always @(posedge clk) begin
    if (!tgt_prog_n) prog_low++;
    if (!tgt_cs_n && !tgt_init && !cfg_err && !kill_init) cs_early++;
    if (!tgt_cs_n) begin
      if (tgt_cclk == prev_clk) run++;
      else begin
        if (run > 0) begin
          if (prev_clk && run < min_hi) min_hi = run;
          if (!prev_clk && run < min_lo) min_lo = run;
        end
        run = 1;
      end
    end else run = 0;
    if (tgt_cclk && !prev_clk) pend = 0;
    if (s_valid && s_ready) begin if (pend != 0) ovl++; pend = 1; end
    prev_clk = tgt_cclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s actual %0d expected %0d", req, act, exp); end
  endtask

  task automatic go(input bit sc);
    @(negedge clk);
    ncap = 0; prog_low = 0; cs_early = 0; min_hi = 99; min_lo = 99; ovl = 0; pend = 0;
    scrub = sc; start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic feed(input int n, input int seed, input int kill_after);
    for (int i = 0; i < n; i++) begin
      if (i == kill_after) kill_init = 1;
      s_data = 8'(seed + i * 37); s_last = (i == n - 1); s_valid = 1;
      while (1) begin
        @(negedge clk);
        if (cfg_err) break;
        if (s_ready) begin @(posedge clk); #1; break; end
      end
      s_valid = 0;
      if (cfg_err) break;
    end
    s_valid = 0; s_last = 0;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 5000 && !cfg_ok && !cfg_err; i++) @(negedge clk);
  endtask

  task automatic check_bytes(input int n, input int seed, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) if (cap[i] !== 8'(seed + i * 37)) bad++;
    chk(bad == 0, req, bad, 0);
  endtask

  task automatic t_reset();
    chk(tgt_prog_n && tgt_cs_n && tgt_rdwr_n && !tgt_cclk, "R1", {tgt_prog_n, tgt_cs_n, tgt_rdwr_n, tgt_cclk}, 4'b1110);
    chk(!s_ready && !cfg_ok && !cfg_err, "R1", {s_ready, cfg_ok, cfg_err}, 0);
  endtask

  task automatic t_normal(input int n, input int seed, input int dextra);
    done_at = n + dextra;
    go(0);
    chk(tgt_cs_n && tgt_rdwr_n, "R4", tgt_cs_n, 1);
    feed(n, seed, -1);
    wait_end();
    chk(cfg_ok && !cfg_err, "R8", cfg_ok, 1);
    chk(prog_low == 64, "R2", prog_low, 64);
    chk(cs_early == 0, "R4", cs_early, 0);
    check_bytes(n, seed, "R5");
    chk(ncap - n >= 8, "R8", ncap - n, 8);
    chk(min_hi >= 2 && min_lo >= 2, "R6", min_hi * 100 + min_lo, 202);
    chk(ovl == 0, "R7", ovl, 0);
    @(negedge clk);
    chk(tgt_cs_n && tgt_rdwr_n && !tgt_cclk, "R4", tgt_cs_n, 1);
  endtask

  task automatic t_scrub();
    done_at = 6 + 3;
    go(1);
    feed(6, 9, -1);
    wait_end();
    chk(prog_low == 0, "R3", prog_low, 0);
    chk(cfg_ok, "R3", cfg_ok, 1);
    check_bytes(6, 9, "R5");
  endtask

  task automatic t_init_loss();
    done_at = 1000;
    go(0);
    feed(10, 3, 4);
    wait_end();
    chk(cfg_err && !cfg_ok, "R9", cfg_err, 1);
    chk(tgt_cs_n, "R9", tgt_cs_n, 1);
    kill_init = 0;
  endtask

  task automatic t_no_done();
    done_at = 100000;
    go(0);
    feed(4, 5, -1);
    wait_end();
    chk(cfg_err, "R10", cfg_err, 1);
    chk(ncap - 4 == 64, "R10", ncap - 4, 64);
  endtask

  task automatic t_no_init();
    hang_init = 1;
    go(0);
    wait_end();
    chk(cfg_err, "R11", cfg_err, 1);
    chk(ncap == 0 && cs_early == 0, "R11", ncap, 0);
    hang_init = 0;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        @(negedge clk);
        t_normal(20, 1, 2);
        t_normal(5, 100, 12);
        t_scrub();
        t_init_loss();
        t_no_done();
        t_no_init();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual 1 expected 0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule